// File: doc/BRIEF.md
# TV Sound Decoder Control Register Slave

This block is the serial control port of a television sound decoder. It runs from a fast system clock and oversamples the two-wire bus lines SCL and SDA. A bus master writes a single 8-bit control byte, or reads back a single 8-bit status byte. SDA is open drain: the block never drives it high, it only asserts a separate pull-low output.

The control byte selects the bilingual channel mode, forced mono, mute, the external input, the clock-output enable, the baseband input mode and test mode. From that byte, the mute pin and the two detector flags, the block decodes a source selection for the left and right audio channels. Three pins choose the device address, so up to three decoders can share one bus.

Top module: `tvsnd_ctrl_slave`

## Requirements
- R1: After reset `ctrlReg` is 0x01, `sdaDriveLow` is 0 and the initial-condition flag (status bit 5) is set.
- R2: The slave answers only an address byte whose upper seven bits match the selected address. The full address byte, with the R/W bit as bit 0, is 0x80 for `addrSel` 00 (open), 0x84 for 01 (high) and 0xA0 for 10 (low); code 11 acts as open. An address that does not match is not acknowledged, and the slave ignores the bytes that follow it.
- R3: Bits travel MSB first. After the 8th bit of a matching address, and after the 8th bit of a write data byte, the slave holds SDA low for the whole 9th clock.
- R4: In a write (R/W = 0), the first data byte replaces `ctrlReg` when its 8th bit is sampled on a rising SCL edge.
- R5: A STOP that arrives before 8 data bits have been received leaves `ctrlReg` unchanged.
- R6: In a read (R/W = 1) the slave sends the status byte {stereoDet, bilingualDet, initFlag, 5'b00000}, bit 7 first. `initFlag` clears on the first completed write.
- R7: The source codes are MUTE=0, MAIN=1, SUB=2, LEFT=3, RIGHT=4, SUM=5, EXTL=6 and EXTR=7. When `mutePin` is high or `ctrlReg[3]` is set, both channels are MUTE.
- R8: When the block is not muted and `ctrlReg[4]` is set, left is EXTL and right is EXTR, whatever the broadcast type.
- R9: A broadcast counts as bilingual when `bilingualDet` is high; this takes priority over `stereoDet`. For a bilingual broadcast with `ctrlReg[2]` (forced mono) set, both channels are MAIN. Otherwise `ctrlReg[1:0]` selects: 00 gives MAIN on the left and SUB on the right, 01 gives MAIN on both, 10 gives SUB on both, and the prohibited 11 gives MAIN on both.
- R10: A stereo broadcast (`stereoDet` high, `bilingualDet` low) gives LEFT and RIGHT. With forced mono set it gives SUM on both channels.
- R11: A mono broadcast (both flags low) gives SUM on both channels, whatever the mode and forced-mono bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | Pulls SDA low when set |
| addrSel | input | 2 | Address strap: 00 open, 01 high, 10 low |
| stereoDet | input | 1 | Stereo broadcast detected |
| bilingualDet | input | 1 | Bilingual broadcast detected |
| mutePin | input | 1 | External mute level |
| ctrlReg | output | 8 | Control register contents |
| srcLeft | output | 3 | Left-channel source code |
| srcRight | output | 3 | Right-channel source code |

## Verification
The routing decode is exercised with every bilingual mode code, including the prohibited one. These cases show whether the mode bits are decoded per channel. Forced mono is applied to each broadcast type, because it has a different effect on each: it gives MAIN on a bilingual broadcast, SUM on a stereo one, and nothing on a mono one. Both detector flags are raised together to check that bilingual takes priority. Bus patterns cover all three address straps against foreign addresses, and a STOP after four data bits. Status reads are made before and after the first write, so that an `initFlag` stuck in either state is caught.

// File: rtl/tvsnd_pkg.sv
package tvsnd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SRC_MUTE  = 3'd0,
    SRC_MAIN  = 3'd1,
    SRC_SUB   = 3'd2,
    SRC_LEFT  = 3'd3,
    SRC_RIGHT = 3'd4,
    SRC_SUM   = 3'd5,
    SRC_EXT_L = 3'd6,
    SRC_EXT_R = 3'd7
  } srcSel_e;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic shiftIn;   // sample one received bit
    logic commitWr;  // last data bit: load control register
    logic loadRd;    // load status byte for transmit
    logic shiftRd;   // advance transmit bit
  } busStrobe_t;
endpackage

// File: rtl/tvsnd_i2c_ctrl.sv
module tvsnd_i2c_ctrl
  import tvsnd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrHit,
  input  logic       rwBit,
  input  logic       txBit,
  output busStrobe_t strobe,
  output logic       sdaBit,
  output logic       sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_CHK, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_SKIP
  } busState_e;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;

  generate
    if (SYNC_STAGES == 1) begin : g_syncOne
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end else begin : g_syncChain
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  logic sclNow, sdaNow, sclPrev, sdaPrev;
  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  logic sclRise, sclFall, startCond, stopCond;
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startCond = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopCond  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  busState_e        state;
  logic [CNT_W-1:0] bitCnt;
  logic             ackOn;
  logic             isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
      isRead <= 1'b0;
    end else if (startCond) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (stopCond) begin
      state <= ST_IDLE;
      ackOn <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= ST_ADDR_CHK;
        end
        ST_ADDR_CHK: begin
          isRead <= rwBit;
          state  <= addrHit ? ST_ADDR_ACK : ST_SKIP;
        end
        ST_ADDR_ACK: if (sclFall) begin
          if (!ackOn) ackOn <= 1'b1;
          else begin
            ackOn  <= 1'b0;
            bitCnt <= '0;
            state  <= isRead ? ST_RD : ST_WR;
          end
        end
        ST_WR: if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == LAST_BIT) state <= ST_WR_ACK;
        end
        ST_WR_ACK: if (sclFall) begin
          if (!ackOn) ackOn <= 1'b1;
          else begin
            ackOn <= 1'b0;
            state <= ST_SKIP;
          end
        end
        ST_RD: if (sclFall) begin
          if (bitCnt == LAST_BIT) state <= ST_SKIP;
          else bitCnt <= bitCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.shiftIn  = sclRise & ((state == ST_ADDR) | (state == ST_WR));
    strobe.commitWr = sclRise & (state == ST_WR) & (bitCnt == LAST_BIT);
    strobe.loadRd   = sclFall & (state == ST_ADDR_ACK) & ackOn & isRead;
    strobe.shiftRd  = sclFall & (state == ST_RD) & (bitCnt != LAST_BIT);
  end

  assign sdaBit      = sdaNow;
  assign sdaDriveLow = ackOn | ((state == ST_RD) & ~txBit);
endmodule

// File: rtl/tvsnd_reg_path.sv
module tvsnd_reg_path
  import tvsnd_pkg::*;
#(
  parameter logic [6:0]        ADDR_OPEN   = 7'h40,
  parameter logic [6:0]        ADDR_HIGH   = 7'h42,
  parameter logic [6:0]        ADDR_LOW    = 7'h50,
  parameter logic [BYTE_W-1:0] RESET_VALUE = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic              sdaBit,
  input  logic [1:0]        addrSel,
  input  logic              stereoDet,
  input  logic              bilingualDet,
  output logic              addrHit,
  output logic              rwBit,
  output logic              txBit,
  output logic [BYTE_W-1:0] ctrlQ
);
  logic [BYTE_W-1:0] rxShift, txShift, rxNext, statusByte;
  logic              initFlag;
  logic [6:0]        ownAddr;

  assign rxNext     = {rxShift[BYTE_W-2:0], sdaBit};
  assign statusByte = {stereoDet, bilingualDet, initFlag, {(BYTE_W-3){1'b0}}};

  always_comb begin
    unique case (addrSel)
      2'b01:   ownAddr = ADDR_HIGH;
      2'b10:   ownAddr = ADDR_LOW;
      default: ownAddr = ADDR_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '1;
      ctrlQ    <= RESET_VALUE;
      initFlag <= 1'b1;
    end else begin
      if (strobe.shiftIn) rxShift <= rxNext;
      if (strobe.commitWr) begin
        ctrlQ    <= rxNext;
        initFlag <= 1'b0;
      end
      if (strobe.loadRd) txShift <= statusByte;
      else if (strobe.shiftRd) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign addrHit = (rxShift[BYTE_W-1:1] == ownAddr);
  assign rwBit   = rxShift[0];
  assign txBit   = txShift[BYTE_W-1];
endmodule

// File: rtl/tvsnd_route_decode.sv
module tvsnd_route_decode
  import tvsnd_pkg::*;
(
  input  logic [BYTE_W-1:0] ctrlQ,
  input  logic              mutePin,
  input  logic              stereoDet,
  input  logic              bilingualDet,
  output srcSel_e           srcL,
  output srcSel_e           srcR
);
  localparam int MONO_BIT = 2;
  localparam int MUTE_BIT = 3;
  localparam int EXT_BIT  = 4;

  always_comb begin
    if (mutePin || ctrlQ[MUTE_BIT]) begin
      srcL = SRC_MUTE;  srcR = SRC_MUTE;
    end else if (ctrlQ[EXT_BIT]) begin
      srcL = SRC_EXT_L; srcR = SRC_EXT_R;
    end else if (bilingualDet) begin
      if (ctrlQ[MONO_BIT]) begin
        srcL = SRC_MAIN; srcR = SRC_MAIN;
      end else begin
        unique case (ctrlQ[1:0])
          2'b00:   begin srcL = SRC_MAIN; srcR = SRC_SUB;  end
          2'b10:   begin srcL = SRC_SUB;  srcR = SRC_SUB;  end
          default: begin srcL = SRC_MAIN; srcR = SRC_MAIN; end
        endcase
      end
    end else if (stereoDet && !ctrlQ[MONO_BIT]) begin
      srcL = SRC_LEFT; srcR = SRC_RIGHT;
    end else begin
      srcL = SRC_SUM;  srcR = SRC_SUM;
    end
  end
endmodule

// File: rtl/tvsnd_ctrl_slave.sv
module tvsnd_ctrl_slave
  import tvsnd_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [6:0]        ADDR_OPEN   = 7'h40,
  parameter logic [6:0]        ADDR_HIGH   = 7'h42,
  parameter logic [6:0]        ADDR_LOW    = 7'h50,
  parameter logic [BYTE_W-1:0] RESET_VALUE = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  input  logic [1:0]        addrSel,
  input  logic              stereoDet,
  input  logic              bilingualDet,
  input  logic              mutePin,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic [2:0]        srcLeft,
  output logic [2:0]        srcRight
);
  busStrobe_t strobe;
  logic       sdaBit, addrHit, rwBit, txBit;
  srcSel_e    srcL, srcR;

  tvsnd_i2c_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit),
    .strobe(strobe), .sdaBit(sdaBit), .sdaDriveLow(sdaDriveLow)
  );

  tvsnd_reg_path #(
    .ADDR_OPEN(ADDR_OPEN), .ADDR_HIGH(ADDR_HIGH),
    .ADDR_LOW(ADDR_LOW), .RESET_VALUE(RESET_VALUE)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaBit(sdaBit),
    .addrSel(addrSel), .stereoDet(stereoDet), .bilingualDet(bilingualDet),
    .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit), .ctrlQ(ctrlReg)
  );

  tvsnd_route_decode u_route (
    .ctrlQ(ctrlReg), .mutePin(mutePin), .stereoDet(stereoDet),
    .bilingualDet(bilingualDet), .srcL(srcL), .srcR(srcR)
  );

  assign srcLeft  = srcL;
  assign srcRight = srcR;
endmodule

// File: rtl/tvsnd_ctrl_slave_chk.sv
module tvsnd_ctrl_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaDriveLow,
  input logic       stereoDet,
  input logic       bilingualDet,
  input logic       mutePin,
  input logic [7:0] ctrlReg,
  input logic [2:0] srcLeft,
  input logic [2:0] srcRight
);
  // register only loads on a sampled (high) SCL phase
  assert_load_on_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlReg) |-> sclIn);

  // acknowledge and read data start only while SCL is low
  assert_drive_when_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclIn);

  assert_mute_both_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mutePin || ctrlReg[3]) |-> (srcLeft == 3'd0 && srcRight == 3'd0));

  assert_ext_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!mutePin && !ctrlReg[3] && ctrlReg[4]) |-> (srcLeft == 3'd6 && srcRight == 3'd7));

  assert_prohibited_main_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!mutePin && ctrlReg[4:0] == 5'b00011 && bilingualDet)
      |-> (srcLeft == 3'd1 && srcRight == 3'd1));

  assert_mono_sum_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!mutePin && ctrlReg[4:3] == 2'b00 && !bilingualDet && !stereoDet)
      |-> (srcLeft == 3'd5 && srcRight == 3'd5));
endmodule

bind tvsnd_ctrl_slave tvsnd_ctrl_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .stereoDet(stereoDet), .bilingualDet(bilingualDet), .mutePin(mutePin),
  .ctrlReg(ctrlReg), .srcLeft(srcLeft), .srcRight(srcRight)
);

// File: tb/tvsnd_ctrl_slave_test.sv
`timescale 1ns/1ps
module tvsnd_ctrl_slave_test;
  localparam int Q = 10;  // system clocks per quarter bit

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic [1:0] addrSel = 2'b00;
  logic       stereoDet = 1'b0;
  logic       bilingualDet = 1'b0;
  logic       mutePin = 1'b0;
  logic       sdaDriveLow;
  logic [7:0] ctrlReg;
  logic [2:0] srcLeft, srcRight;
  wire        sdaBus = sdaM & ~sdaDriveLow;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  tvsnd_ctrl_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .addrSel(addrSel), .stereoDet(stereoDet),
    .bilingualDet(bilingualDet), .mutePin(mutePin), .ctrlReg(ctrlReg),
    .srcLeft(srcLeft), .srcRight(srcRight)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitQ(1);
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(1);
    sclM = 1'b1; waitQ(1);
    sdaM = 1'b1; waitQ(2);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitQ(1);
    sclM = 1'b1; waitQ(2);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic recvBit(output logic b);
    sdaM = 1'b1; waitQ(1);
    sclM = 1'b1; waitQ(1);
    b = sdaBus; waitQ(1);
    sclM = 1'b0; waitQ(1);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic writeCtrl(input logic [7:0] addr, input logic [7:0] d,
                           output logic ackA, output logic ackD);
    busStart();
    sendByte(addr, ackA);
    sendByte(d, ackD);
    busStop();
  endtask

  task automatic readStatus(input logic [7:0] addr, output logic ackA,
                            output logic [7:0] d);
    logic b;
    busStart();
    sendByte(addr | 8'h01, ackA);
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      d[i] = b;
    end
    sendBit(1'b1);
    busStop();
  endtask

  task automatic checkRoute(input string req, input logic [2:0] l, input logic [2:0] r);
    repeat (3) @(negedge clk);
    check(req, {2'b00, srcLeft, srcRight}, {2'b00, l, r});
  endtask

  task automatic testReset();
    check("R1 ctrlReg", ctrlReg, 8'h01);
    check("R1 sdaDriveLow", {7'd0, sdaDriveLow}, 8'h00);
    checkRoute("R11 reset mono", 3'd5, 3'd5);
  endtask

  task automatic testReadInitial();
    logic a; logic [7:0] d;
    stereoDet = 1'b1; bilingualDet = 1'b0;
    readStatus(8'h80, a, d);
    check("R3 read addr ack", {7'd0, a}, 8'h01);
    check("R6 status initial", d, 8'hA0);
  endtask

  task automatic testWrite();
    logic a, b; logic [7:0] d;
    writeCtrl(8'h80, 8'h00, a, b);
    check("R3 addr ack", {7'd0, a}, 8'h01);
    check("R3 data ack", {7'd0, b}, 8'h01);
    check("R4 ctrl written", ctrlReg, 8'h00);
    stereoDet = 1'b0; bilingualDet = 1'b1;
    readStatus(8'h80, a, d);
    check("R6 status after write", d, 8'h40);
  endtask

  task automatic testAddresses();
    logic a, b;
    writeCtrl(8'h84, 8'h55, a, b);
    check("R2 foreign addr no ack", {7'd0, a}, 8'h00);
    check("R2 foreign addr ignored", ctrlReg, 8'h00);
    addrSel = 2'b01;
    writeCtrl(8'h84, 8'h02, a, b);
    check("R2 high strap", ctrlReg, 8'h02);
    writeCtrl(8'h80, 8'h55, a, b);
    check("R2 open addr rejected when high", {7'd0, a}, 8'h00);
    addrSel = 2'b10;
    writeCtrl(8'hA0, 8'h06, a, b);
    check("R2 low strap", ctrlReg, 8'h06);
    addrSel = 2'b11;
    writeCtrl(8'h80, 8'h00, a, b);
    check("R2 code 11 as open", ctrlReg, 8'h00);
    addrSel = 2'b00;
  endtask

  task automatic testPartial();
    logic a;
    busStart();
    sendByte(8'h80, a);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop();
    check("R5 partial discarded", ctrlReg, 8'h00);
  endtask

  task automatic setCtrl(input logic [7:0] v);
    logic a, b;
    writeCtrl(8'h80, v, a, b);
  endtask

  task automatic testRouting();
    stereoDet = 1'b0; bilingualDet = 1'b1;
    setCtrl(8'h00); checkRoute("R9 mode 00", 3'd1, 3'd2);
    setCtrl(8'h01); checkRoute("R9 mode 01", 3'd1, 3'd1);
    setCtrl(8'h02); checkRoute("R9 mode 10", 3'd2, 3'd2);
    setCtrl(8'h03); checkRoute("R9 mode 11", 3'd1, 3'd1);
    setCtrl(8'h06); checkRoute("R9 forced mono", 3'd1, 3'd1);
    stereoDet = 1'b1;
    setCtrl(8'h00); checkRoute("R9 bilingual priority", 3'd1, 3'd2);
    bilingualDet = 1'b0;
    checkRoute("R10 stereo", 3'd3, 3'd4);
    setCtrl(8'h04); checkRoute("R10 stereo forced", 3'd5, 3'd5);
    stereoDet = 1'b0;
    setCtrl(8'h02); checkRoute("R11 mono mode", 3'd5, 3'd5);
    setCtrl(8'h04); checkRoute("R11 mono forced", 3'd5, 3'd5);
    stereoDet = 1'b1;
    setCtrl(8'h10); checkRoute("R8 external", 3'd6, 3'd7);
    setCtrl(8'h18); checkRoute("R7 mute bit", 3'd0, 3'd0);
    setCtrl(8'h00);
    mutePin = 1'b1; checkRoute("R7 mute pin", 3'd0, 3'd0);
    mutePin = 1'b0; checkRoute("R7 mute released", 3'd3, 3'd4);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testReadInitial();
    testWrite();
    testAddresses();
    testPartial();
    testRouting();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule